// File: doc/BRIEF.md
# Odd-Parity Single-Error Correcting Code Unit

This block protects nine data bits with four check bits in a 13-bit codeword and repairs any single flipped bit on the way back in. The convention is odd parity: every check group of a healthy word holds an odd number of ones. The unit holds two paths. The encoder path is combinational. It turns nine data bits into a complete codeword. The decoder path takes one received word per cycle when a valid strobe is high. It recomputes the four group parities and forms a 4-bit syndrome that names the bad position. It then inverts that position and returns the repaired word, the nine recovered data bits, the syndrome and two flags, all registered one cycle later.

Bit position p (1 to 13) sits at word bit p-1. Check bits live at positions 1, 2, 4 and 8. The other positions carry data. A syndrome value above 13 cannot name a real position. Such a word is flagged as uncorrectable and returned as received. Detecting double errors is not part of this block.

Top module: `ham_corrector`

## Requirements
- R1: Syndrome bit k (k = 0..3) covers every position p whose binary value has bit k set. It is 1 when that group of the received word holds an even number of ones, and 0 when the count is odd.
- R2: When the syndrome is between 1 and 13, the repaired word equals the received word with position syndrome (word bit syndrome-1) inverted, and the error flag is 1.
- R3: A syndrome of 0 leaves the word unchanged, with both the error flag and the uncorrectable flag at 0.
- R4: A syndrome of 14 or 15 sets both the uncorrectable flag and the error flag to 1, and the word is passed on unmodified.
- R5: Data output bits 0 to 8 are taken from positions 3, 5, 6, 7, 9, 10, 11, 12 and 13 of the repaired word, in that order.
- R6: The encoder places data bits 0 to 8 at positions 3, 5, 6, 7, 9, 10, 11, 12 and 13. It sets the check bits at positions 1, 2, 4 and 8 so that each group of R1 has odd parity. The encoder is combinational.
- R7: The decoder results appear and out_valid_o is 1 in the cycle after the one in which rx_valid_i was sampled high. out_valid_o is 0 after a cycle with rx_valid_i low. In that case the result outputs hold their previous values.
- R8: While rst is high at a clock edge, out_valid_o and all decoder result outputs are cleared to 0.
- R9: The received word 13'b0011100101101 gives syndrome 7, repaired word 13'b0011101101101 and data 9'h07D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enc_data_i | input | 9 | Data to be encoded |
| enc_word_o | output | 13 | Encoded codeword (combinational) |
| rx_valid_i | input | 1 | Received word is valid this cycle |
| rx_word_i | input | 13 | Received codeword |
| out_valid_o | output | 1 | Decoder results valid |
| fix_word_o | output | 13 | Repaired codeword |
| fix_data_o | output | 9 | Data recovered from the repaired word |
| syndrome_o | output | 4 | Syndrome, value = suspected position |
| err_o | output | 1 | Nonzero syndrome seen |
| uncorr_o | output | 1 | Syndrome names no position (14 or 15) |

## Verification
The decoder keeps only one stage of state: the captured result and its valid bit. A wrong syndrome, a wrong flip or a stale capture therefore appears at the outputs in the very next cycle after the offending word. It shows as a repaired word that still fails odd parity in some group, or as more than one bit differing from the received word. A hold fault appears in the first idle cycle that follows. Every single-bit position is injected on many data values, so a group mask that is off by one position cannot hide. The two syndromes that fall past the word are forced with paired flips.

// File: rtl/ham_pkg.sv
package ham_pkg;

    localparam int unsigned CHK_W  = 4;
    localparam int unsigned WORD_W = 13;
    localparam int unsigned DATA_W = WORD_W - CHK_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CHK_W-1:0]  synd_t;

    typedef struct packed {
        word_t word;
        data_t data;
        synd_t synd;
        logic  err;
        logic  uncorr;
    } fix_res_t;

    // Mask of the positions covered by check group k (position p at bit p-1)
    function automatic word_t group_mask(int unsigned k);
        word_t m;
        m = '0;
        for (int unsigned p = 1; p <= WORD_W; p++) begin
            if (((p >> k) & 32'd1) != 32'd0) m[p-1] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic is_check_pos(int unsigned p);
        return ((p & (p - 32'd1)) == 32'd0);
    endfunction

    // Position (1-based) carrying data bit i, data positions in ascending order
    function automatic int unsigned data_pos(int unsigned i);
        int unsigned n;
        int unsigned r;
        n = 0;
        r = 0;
        for (int unsigned p = 1; p <= WORD_W; p++) begin
            if (!is_check_pos(p)) begin
                if (n == i) r = p;
                n++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ham_syndrome.sv
module ham_syndrome
    import ham_pkg::*;
(
    input  word_t word_i,
    output synd_t synd_o
);
    for (genvar k = 0; k < CHK_W; k++) begin : g_grp
        localparam word_t MASK = group_mask(k);
        // odd parity expected: an even group count flags the group
        assign synd_o[k] = ~(^(word_i & MASK));
    end
endmodule

// File: rtl/ham_fix.sv
module ham_fix
    import ham_pkg::*;
(
    input  word_t word_i,
    input  synd_t synd_i,
    output word_t word_o,
    output logic  err_o,
    output logic  uncorr_o
);
    word_t flip;

    for (genvar p = 1; p <= WORD_W; p++) begin : g_pos
        assign flip[p-1] = (synd_i == synd_t'(p));
    end

    assign word_o   = word_i ^ flip;
    assign err_o    = (synd_i != '0);
    assign uncorr_o = (synd_i > synd_t'(WORD_W));
endmodule

// File: rtl/ham_extract.sv
module ham_extract
    import ham_pkg::*;
(
    input  word_t word_i,
    output data_t data_o
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_dat
        localparam int unsigned POS = data_pos(i);
        assign data_o[i] = word_i[POS-1];
    end
endmodule

// File: rtl/ham_encoder.sv
module ham_encoder
    import ham_pkg::*;
(
    input  data_t data_i,
    output word_t word_o
);
    word_t placed;
    synd_t chk;

    always_comb begin
        placed = '0;
        for (int unsigned i = 0; i < DATA_W; i++) begin
            placed[data_pos(i)-1] = data_i[i];
        end
    end

    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        localparam word_t MASK = group_mask(k);
        assign chk[k] = ~(^(placed & MASK));
    end

    always_comb begin
        word_o = placed;
        for (int unsigned k = 0; k < CHK_W; k++) begin
            word_o[(1 << k) - 1] = chk[k];
        end
    end
endmodule

// File: rtl/ham_corrector.sv
module ham_corrector
    import ham_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [8:0]  enc_data_i,
    output logic [12:0] enc_word_o,
    input  logic        rx_valid_i,
    input  logic [12:0] rx_word_i,
    output logic        out_valid_o,
    output logic [12:0] fix_word_o,
    output logic [8:0]  fix_data_o,
    output logic [3:0]  syndrome_o,
    output logic        err_o,
    output logic        uncorr_o
);
    fix_res_t res_d;
    fix_res_t res_q;
    logic     vld_q;

    ham_encoder u_enc (
        .data_i (enc_data_i),
        .word_o (enc_word_o)
    );

    ham_syndrome u_syn (
        .word_i (rx_word_i),
        .synd_o (res_d.synd)
    );

    ham_fix u_fix (
        .word_i   (rx_word_i),
        .synd_i   (res_d.synd),
        .word_o   (res_d.word),
        .err_o    (res_d.err),
        .uncorr_o (res_d.uncorr)
    );

    ham_extract u_ext (
        .word_i (res_d.word),
        .data_o (res_d.data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= rx_valid_i;
            if (rx_valid_i) res_q <= res_d;
        end
    end

    assign out_valid_o = vld_q;
    assign fix_word_o  = res_q.word;
    assign fix_data_o  = res_q.data;
    assign syndrome_o  = res_q.synd;
    assign err_o       = res_q.err;
    assign uncorr_o    = res_q.uncorr;
endmodule

// File: rtl/ham_corrector_chk.sv
module ham_corrector_chk
    import ham_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [12:0] enc_word_o,
    input logic        rx_valid_i,
    input logic [12:0] rx_word_i,
    input logic        out_valid_o,
    input logic [12:0] fix_word_o,
    input logic [8:0]  fix_data_o,
    input logic        err_o,
    input logic        uncorr_o
);
    function automatic logic all_odd(word_t w);
        logic ok;
        ok = 1'b1;
        for (int unsigned k = 0; k < CHK_W; k++) begin
            if (~^(w & group_mask(k))) ok = 1'b0;
        end
        return ok;
    endfunction

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid_i |=> out_valid_o);
    // R7
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid_i |=> !out_valid_o);
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid_i |=> $stable(fix_word_o));
    // R1
    repaired_odd_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !uncorr_o) |-> all_odd(fix_word_o));
    // R2
    single_flip_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> ($countones(fix_word_o ^ $past(rx_word_i)) <= 1));
    // R3
    clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !err_o) |-> (fix_word_o == $past(rx_word_i)));
    // R4
    uncorr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && uncorr_o) |-> (err_o && fix_word_o == $past(rx_word_i)));
    // R5
    data_edge_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> (fix_data_o[0] == fix_word_o[2] && fix_data_o[8] == fix_word_o[12]));
    // R6
    enc_odd_chk: assert property (@(posedge clk) disable iff (rst)
        all_odd(enc_word_o));
endmodule

bind ham_corrector ham_corrector_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .enc_word_o  (enc_word_o),
    .rx_valid_i  (rx_valid_i),
    .rx_word_i   (rx_word_i),
    .out_valid_o (out_valid_o),
    .fix_word_o  (fix_word_o),
    .fix_data_o  (fix_data_o),
    .err_o       (err_o),
    .uncorr_o    (uncorr_o)
);

// File: tb/ham_corrector_bench.sv
module ham_corrector_bench;

    typedef struct {
        logic [12:0] word;
        logic [8:0]  data;
        logic [3:0]  synd;
        logic        err;
        logic        uncorr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  enc_data_i = '0;
    logic [12:0] enc_word_o;
    logic        rx_valid_i = 1'b0;
    logic [12:0] rx_word_i = '0;
    logic        out_valid_o;
    logic [12:0] fix_word_o;
    logic [8:0]  fix_data_o;
    logic [3:0]  syndrome_o;
    logic        err_o;
    logic        uncorr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [12:0] last_word = '0;
    exp_t sb[$];

    localparam int DPOS [9] = '{3, 5, 6, 7, 9, 10, 11, 12, 13};

    always #5 clk = ~clk;

    ham_corrector u_ham_corrector (
        .clk         (clk),
        .rst         (rst),
        .enc_data_i  (enc_data_i),
        .enc_word_o  (enc_word_o),
        .rx_valid_i  (rx_valid_i),
        .rx_word_i   (rx_word_i),
        .out_valid_o (out_valid_o),
        .fix_word_o  (fix_word_o),
        .fix_data_o  (fix_data_o),
        .syndrome_o  (syndrome_o),
        .err_o       (err_o),
        .uncorr_o    (uncorr_o)
    );

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] model_synd(logic [12:0] w);
        logic [3:0] s;
        for (int k = 0; k < 4; k++) begin
            int cnt;
            cnt = 0;
            for (int p = 1; p <= 13; p++) begin
                if (((p >> k) & 1) == 1 && w[p-1]) cnt++;
            end
            s[k] = (cnt % 2 == 0);
        end
        return s;
    endfunction

    function automatic logic [8:0] model_data(logic [12:0] w);
        logic [8:0] d;
        for (int i = 0; i < 9; i++) d[i] = w[DPOS[i]-1];
        return d;
    endfunction

    function automatic logic [12:0] model_enc(logic [8:0] d);
        logic [12:0] w;
        w = '0;
        for (int i = 0; i < 9; i++) w[DPOS[i]-1] = d[i];
        for (int k = 0; k < 4; k++) begin
            int cnt;
            cnt = 0;
            for (int p = 1; p <= 13; p++) begin
                if (((p >> k) & 1) == 1 && w[p-1]) cnt++;
            end
            w[(1 << k) - 1] = (cnt % 2 == 0);
        end
        return w;
    endfunction

    task automatic push_send(logic [12:0] w, exp_t e);
        @(negedge clk);
        rx_valid_i = 1'b1;
        rx_word_i  = w;
        sb.push_back(e);
    endtask

    task automatic send(logic [12:0] w);
        exp_t e;
        e.synd   = model_synd(w);
        e.err    = (e.synd != 0);
        e.uncorr = (e.synd > 13);
        e.word   = w;
        if (e.err && !e.uncorr) e.word[e.synd-1] = ~e.word[e.synd-1];
        e.data   = model_data(e.word);
        e.tag    = !e.err ? "R3" : (e.uncorr ? "R4" : "R2");
        push_send(w, e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid_i = 1'b0;
            rx_word_i  = 13'($urandom);
        end
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst) begin
                if (out_valid_o) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R7", "unexpected valid", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(fix_word_o == e.word, e.tag, "word", fix_word_o, e.word);
                        check(syndrome_o == e.synd, "R1", "syndrome", syndrome_o, e.synd);
                        check(fix_data_o == e.data, "R5", "data", fix_data_o, e.data);
                        check(err_o == e.err, e.tag, "err flag", err_o, e.err);
                        check(uncorr_o == e.uncorr, e.tag, "uncorr flag", uncorr_o, e.uncorr);
                        last_word = fix_word_o;
                    end
                end else begin
                    // R7 hold while idle
                    check(fix_word_o == last_word, "R7", "hold", fix_word_o, last_word);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t ex;
        repeat (3) @(posedge clk);
        #1;
        // R8 reset state
        check(out_valid_o == 1'b0, "R8", "valid in reset", out_valid_o, 0);
        check(fix_word_o == '0, "R8", "word in reset", fix_word_o, 0);
        check({fix_data_o, syndrome_o, err_o, uncorr_o} == '0, "R8", "fields in reset",
              {fix_data_o, syndrome_o, err_o, uncorr_o}, 0);
        @(negedge clk);
        rst = 1'b0;

        // R9 worked example with fixed expectations
        ex.word = 13'b0011101101101;
        ex.data = 9'h07D;
        ex.synd = 4'd7;
        ex.err = 1'b1;
        ex.uncorr = 1'b0;
        ex.tag = "R9";
        push_send(13'b0011100101101, ex);
        idle(2);

        for (int n = 0; n < 24; n++) begin
            logic [8:0]  d;
            logic [12:0] cw;
            d = (n == 0) ? 9'h000 : ((n == 1) ? 9'h1FF : 9'($urandom));
            @(negedge clk);
            enc_data_i = d;
            #1;
            cw = model_enc(d);
            check(enc_word_o == cw, "R6", "encoder", enc_word_o, cw);
            send(cw);
            for (int p = 1; p <= 13; p++) begin
                logic [12:0] bad;
                bad = cw;
                bad[p-1] = ~bad[p-1];
                send(bad);
                if (p % 5 == 0) idle(1);
            end
            // R4: paired flips that point past the word (6^8=14, 7^8=15)
            send(cw ^ 13'b0000010100000);
            send(cw ^ 13'b0000011000000);
            idle(2);
        end

        idle(4);
        check(sb.size() == 0, "R7", "scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule